// File: doc/BRIEF.md
# Cipher Mode and Key Control Register

This block is the configuration front end of a block-cipher engine. It holds one 32-bit mode word. The word selects the cipher direction, the algorithm (single DES, triple DES or XTEA), the chaining mode, the start mode, the feedback width for cipher-feedback chaining, the last-output behaviour and several key options. Software updates the word with 32-bit writes. A write-protect input, driven by a separate protection register, can veto those writes.

Around that word the block keeps the keys. Three 64-bit software key slots are loaded one 32-bit word at a time. A private key store is loaded in a single transfer over a dedicated private-key bus. A mode bit chooses which of the two sources feeds the datapath. A write-once bit in the mode word arms a lock that only hardware reset releases; while the lock is armed, the private store takes a single load. A tamper input can wipe the software key slots, but only when the mode word arms it.

The block routes the chosen keys onto three 64-bit key outputs according to the algorithm and the two-key option. The cipher datapath reads those outputs directly.

Top module: `cipher_modekey_ctl`

## Requirements
- R1: After reset, the mode readback is 0x00000002. That value means decrypt, triple DES, ECB, manual start and every option clear. All key slots and the private store read as zero, and the write-once lock is released.
- R2: An accepted mode write stores the defined fields and the readback returns them. The fields are: bit 0 direction (1 encrypt), bits 2:1 algorithm (0 single DES, 1 triple DES, 2 XTEA), bit 4 two-key option, bit 6 write-once, bit 7 private-key select, bits 9:8 start mode, bits 13:12 chaining (0 ECB, 1 CBC, 2 OFB, 3 CFB), bit 15 last-output mode, bits 17:16 feedback width (0 = 64, 1 = 32, 2 = 16, 3 = 8 bits) and bit 31 tamper-wipe arm. Every other bit reads 0. The decoded field outputs follow the stored word from the cycle after the write.
- R3: A mode write presented while `mode_wr_prot` is 1 leaves the whole mode word unchanged.
- R4: An accepted write whose algorithm field is 3 (reserved) keeps the previous algorithm value. The other fields of that write are still stored.
- R5: A key write with index i stores its data in software slot i/2. An even index writes bits 31:0 and an odd index writes bits 63:32. Index 6 and index 7 change nothing.
- R6: While bit 31 of the mode word is 1, a tamper pulse clears all three software slots at the next clock edge, and this takes priority over a key write in the same cycle. While bit 31 is 0, a tamper pulse has no effect.
- R7: Any accepted write with bit 6 set arms the lock. Only reset releases it. A later write of 0 to bit 6 makes the readback show 0, but the lock stays armed.
- R8: While the lock is released, every private-key load is stored. While the lock is armed, a load is stored only if no load has been stored since reset.
- R9: With bit 7 = 1 the key outputs draw from the private store (bits 63:0 are key 1, 127:64 key 2, 191:128 key 3). With bit 7 = 0 they draw from the software slots.
- R10: Key A always carries key 1. Single DES drives key B and key C to zero. XTEA drives key 2 on key B and zero on key C. Triple DES drives key 2 on key B and key 3 on key C, or key 1 on key C when the two-key bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| mode_wr_en | input | 1 | Mode word write strobe |
| mode_wr_prot | input | 1 | Write-protect enable from the protection register |
| mode_wr_data | input | 32 | Mode write data |
| key_wr_en | input | 1 | Software key word write strobe |
| key_wr_idx | input | 3 | Key word index (slot*2 + upper half) |
| key_wr_data | input | 32 | Key word data |
| pk_load | input | 1 | Private-key bus load strobe |
| pk_data | input | 192 | Private-key bus data (three 64-bit keys) |
| tamper_i | input | 1 | Tamper detection pulse |
| mode_rd_o | output | 32 | Mode word readback |
| encrypt_o | output | 1 | 1 = encrypt, 0 = decrypt |
| alg_o | output | 2 | Selected algorithm |
| chain_o | output | 2 | Chaining mode |
| start_o | output | 2 | Start mode |
| cfb_size_o | output | 2 | Feedback width code |
| last_out_o | output | 1 | Last-output mode |
| key_a_o | output | 64 | First key to the datapath |
| key_b_o | output | 64 | Second key to the datapath |
| key_c_o | output | 64 | Third key to the datapath |

## Verification
The write-once lock is internal state, so a stuck or wrongly released lock shows only indirectly. It appears as a private-key load that does or does not reach the key outputs. That happens on the first load after the lock changes, and only while private-key select is 1. A wrong algorithm field or a lost reserved-value hold shows on the readback and on the key B and key C routing one cycle after the write. A tamper wipe that did not happen shows as nonzero key outputs in the cycle after the pulse. The bench therefore mixes random writes, loads and tamper pulses, and it compares the mode readback and all key outputs against a model after every operation.

// File: rtl/cmk_pkg.sv
package cmk_pkg;

   localparam int unsigned MODE_W    = 32;
   localparam int unsigned POS_ENC   = 0;
   localparam int unsigned POS_ALG   = 1;
   localparam int unsigned POS_TWO   = 4;
   localparam int unsigned POS_ONCE  = 6;
   localparam int unsigned POS_PKSEL = 7;
   localparam int unsigned POS_START = 8;
   localparam int unsigned POS_CHAIN = 12;
   localparam int unsigned POS_LAST  = 15;
   localparam int unsigned POS_CFB   = 16;
   localparam int unsigned POS_TAMP  = 31;

   typedef enum logic [1:0] {
      ALG_SINGLE = 2'd0,
      ALG_TRIPLE = 2'd1,
      ALG_XTEA   = 2'd2,
      ALG_RSVD   = 2'd3
   } alg_e;

   typedef enum logic [1:0] {
      CH_ECB = 2'd0,
      CH_CBC = 2'd1,
      CH_OFB = 2'd2,
      CH_CFB = 2'd3
   } chain_e;

   typedef struct packed {
      logic       tamp_wipe;
      logic [1:0] cfb_sz;
      logic       last_out;
      chain_e     chain;
      logic [1:0] start;
      logic       pk_sel;
      logic       pk_once;
      logic       two_key;
      alg_e       alg;
      logic       enc;
   } mode_t;

   localparam mode_t MODE_RST = '{
      tamp_wipe: 1'b0, cfb_sz: 2'd0, last_out: 1'b0, chain: CH_ECB,
      start: 2'd0, pk_sel: 1'b0, pk_once: 1'b0, two_key: 1'b0,
      alg: ALG_TRIPLE, enc: 1'b0};

   function automatic logic [MODE_W-1:0] mode_pack(mode_t m);
      logic [MODE_W-1:0] r;
      r                  = '0;
      r[POS_ENC]         = m.enc;
      r[POS_ALG +: 2]    = m.alg;
      r[POS_TWO]         = m.two_key;
      r[POS_ONCE]        = m.pk_once;
      r[POS_PKSEL]       = m.pk_sel;
      r[POS_START +: 2]  = m.start;
      r[POS_CHAIN +: 2]  = m.chain;
      r[POS_LAST]        = m.last_out;
      r[POS_CFB +: 2]    = m.cfb_sz;
      r[POS_TAMP]        = m.tamp_wipe;
      return r;
   endfunction

   function automatic mode_t mode_unpack(logic [MODE_W-1:0] d);
      mode_t m;
      m.enc       = d[POS_ENC];
      m.alg       = alg_e'(d[POS_ALG +: 2]);
      m.two_key   = d[POS_TWO];
      m.pk_once   = d[POS_ONCE];
      m.pk_sel    = d[POS_PKSEL];
      m.start     = d[POS_START +: 2];
      m.chain     = chain_e'(d[POS_CHAIN +: 2]);
      m.last_out  = d[POS_LAST];
      m.cfb_sz    = d[POS_CFB +: 2];
      m.tamp_wipe = d[POS_TAMP];
      return m;
   endfunction

endpackage

// File: rtl/cmk_mode_reg.sv
module cmk_mode_reg
   import cmk_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_prot,
   input  logic [MODE_W-1:0] wr_data,
   output mode_t             mode_o,
   output logic [MODE_W-1:0] rd_o,
   output logic              lock_o
);

   mode_t mode_q;
   mode_t mode_d;
   logic  lock_q;
   logic  accept;

   assign accept = wr_en && !wr_prot;

   always_comb begin
      mode_d = mode_unpack(wr_data);
      if (mode_d.alg == ALG_RSVD) begin
         mode_d.alg = mode_q.alg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         lock_q <= 1'b0;
      end else if (accept) begin
         mode_q <= mode_d;
         if (mode_d.pk_once) begin
            lock_q <= 1'b1;
         end
      end
   end

   assign mode_o = mode_q;
   assign rd_o   = mode_pack(mode_q);
   assign lock_o = lock_q;

endmodule

// File: rtl/cmk_sw_keys.sv
module cmk_sw_keys #(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned NUM_KEYS = 3,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [BUS_W-1:0]                   wr_data,
   input  logic                               wipe,
   output logic [NUM_KEYS-1:0][KEY_W-1:0]     keys_o
);

   localparam int unsigned WPK = KEY_W / BUS_W;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
      for (genvar w = 0; w < WPK; w++) begin : g_word
         localparam int unsigned SLOT = k * WPK + w;
         logic [BUS_W-1:0] word_q;
         logic             hit;

         assign hit = wr_en && (wr_idx == IDX_W'(SLOT));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (wipe) begin
               word_q <= '0;
            end else if (hit) begin
               word_q <= wr_data;
            end
         end

         assign keys_o[k][w*BUS_W +: BUS_W] = word_q;
      end
   end

endmodule

// File: rtl/cmk_pk_store.sv
module cmk_pk_store #(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned NUM_KEYS = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic [NUM_KEYS*KEY_W-1:0]      data,
   input  logic                           lock,
   output logic [NUM_KEYS-1:0][KEY_W-1:0] keys_o,
   output logic                           filled_o
);

   logic [NUM_KEYS-1:0][KEY_W-1:0] store_q;
   logic                           filled_q;
   logic                           take;

   assign take = load && (!lock || !filled_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q  <= '0;
         filled_q <= 1'b0;
      end else if (take) begin
         store_q  <= data;
         filled_q <= 1'b1;
      end
   end

   assign keys_o   = store_q;
   assign filled_o = filled_q;

endmodule

// File: rtl/cmk_key_route.sv
module cmk_key_route
   import cmk_pkg::*;
#(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned NUM_KEYS = 3
) (
   input  mode_t                          mode,
   input  logic [NUM_KEYS-1:0][KEY_W-1:0] sw_keys,
   input  logic [NUM_KEYS-1:0][KEY_W-1:0] pk_keys,
   output logic [KEY_W-1:0]               key_a,
   output logic [KEY_W-1:0]               key_b,
   output logic [KEY_W-1:0]               key_c
);

   logic [NUM_KEYS-1:0][KEY_W-1:0] src;

   assign src = mode.pk_sel ? pk_keys : sw_keys;

   always_comb begin
      key_a = src[0];
      key_b = '0;
      key_c = '0;
      unique case (mode.alg)
         ALG_TRIPLE: begin
            key_b = src[1];
            key_c = mode.two_key ? src[0] : src[2];
         end
         ALG_XTEA: begin
            key_b = src[1];
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/cipher_modekey_ctl.sv
module cipher_modekey_ctl
   import cmk_pkg::*;
#(
   parameter int unsigned KEY_W = 64,
   parameter int unsigned BUS_W = 32,
   localparam int unsigned NUM_KEYS = 3,
   localparam int unsigned WPK      = KEY_W / BUS_W,
   localparam int unsigned IDX_W    = $clog2(NUM_KEYS * WPK + 1),
   localparam int unsigned PK_W     = NUM_KEYS * KEY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_en,
   input  logic              mode_wr_prot,
   input  logic [31:0]       mode_wr_data,
   input  logic              key_wr_en,
   input  logic [IDX_W-1:0]  key_wr_idx,
   input  logic [BUS_W-1:0]  key_wr_data,
   input  logic              pk_load,
   input  logic [PK_W-1:0]   pk_data,
   input  logic              tamper_i,
   output logic [31:0]       mode_rd_o,
   output logic              encrypt_o,
   output logic [1:0]        alg_o,
   output logic [1:0]        chain_o,
   output logic [1:0]        start_o,
   output logic [1:0]        cfb_size_o,
   output logic              last_out_o,
   output logic [KEY_W-1:0]  key_a_o,
   output logic [KEY_W-1:0]  key_b_o,
   output logic [KEY_W-1:0]  key_c_o
);

   if (BUS_W == 0 || KEY_W < BUS_W || (KEY_W % BUS_W) != 0) begin : g_bad_width
      $error("cipher_modekey_ctl: KEY_W must be a nonzero multiple of BUS_W");
   end

   mode_t                          mode_q;
   logic                           pk_lock;
   logic                           pk_filled;
   logic                           sw_wipe;
   logic [NUM_KEYS-1:0][KEY_W-1:0] sw_keys;
   logic [NUM_KEYS-1:0][KEY_W-1:0] pk_keys;

   cmk_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_wr_en),
      .wr_prot (mode_wr_prot),
      .wr_data (mode_wr_data),
      .mode_o  (mode_q),
      .rd_o    (mode_rd_o),
      .lock_o  (pk_lock)
   );

   assign sw_wipe = tamper_i && mode_q.tamp_wipe;

   cmk_sw_keys #(
      .KEY_W    (KEY_W),
      .BUS_W    (BUS_W),
      .NUM_KEYS (NUM_KEYS),
      .IDX_W    (IDX_W)
   ) u_sw (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (key_wr_en),
      .wr_idx  (key_wr_idx),
      .wr_data (key_wr_data),
      .wipe    (sw_wipe),
      .keys_o  (sw_keys)
   );

   cmk_pk_store #(
      .KEY_W    (KEY_W),
      .NUM_KEYS (NUM_KEYS)
   ) u_pk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pk_load),
      .data     (pk_data),
      .lock     (pk_lock),
      .keys_o   (pk_keys),
      .filled_o (pk_filled)
   );

   cmk_key_route #(
      .KEY_W    (KEY_W),
      .NUM_KEYS (NUM_KEYS)
   ) u_route (
      .mode    (mode_q),
      .sw_keys (sw_keys),
      .pk_keys (pk_keys),
      .key_a   (key_a_o),
      .key_b   (key_b_o),
      .key_c   (key_c_o)
   );

   assign encrypt_o  = mode_q.enc;
   assign alg_o      = mode_q.alg;
   assign chain_o    = mode_q.chain;
   assign start_o    = mode_q.start;
   assign cfb_size_o = mode_q.cfb_sz;
   assign last_out_o = mode_q.last_out;

endmodule

// File: rtl/cmk_ctl_chk.sv
module cmk_ctl_chk #(
   parameter int unsigned KEY_W    = 64,
   parameter int unsigned NUM_KEYS = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic                           wr_prot,
   input logic [31:0]                    wr_data,
   input logic [31:0]                    rd,
   input logic                           tamper,
   input logic                           lock,
   input logic                           pk_load,
   input logic                           pk_filled,
   input logic [NUM_KEYS-1:0][KEY_W-1:0] sw_keys,
   input logic [NUM_KEYS-1:0][KEY_W-1:0] pk_keys
);

   // R3
   prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_prot) |=> $stable(rd));

   // R4
   rsvd_alg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_prot && wr_data[2:1] == 2'b11) |=> $stable(rd[2:1]));

   // R2
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd & ~32'h8003_B3D7) == 32'h0);

   // R6
   tamper_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tamper && rd[31]) |=> (sw_keys == '0));

   // R7
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   // R8
   pk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_load && lock && pk_filled) |=> $stable(pk_keys));

endmodule

bind cipher_modekey_ctl cmk_ctl_chk #(
   .KEY_W    (KEY_W),
   .NUM_KEYS (NUM_KEYS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (mode_wr_en),
   .wr_prot   (mode_wr_prot),
   .wr_data   (mode_wr_data),
   .rd        (mode_rd_o),
   .tamper    (tamper_i),
   .lock      (pk_lock),
   .pk_load   (pk_load),
   .pk_filled (pk_filled),
   .sw_keys   (sw_keys),
   .pk_keys   (pk_keys)
);

// File: tb/cipher_modekey_ctl_test.sv
module cipher_modekey_ctl_test;

   localparam logic [31:0] MASK = 32'h8003_B3D7;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         mode_wr_en, mode_wr_prot;
   logic [31:0]  mode_wr_data;
   logic         key_wr_en;
   logic [2:0]   key_wr_idx;
   logic [31:0]  key_wr_data;
   logic         pk_load;
   logic [191:0] pk_data;
   logic         tamper_i;
   logic [31:0]  mode_rd_o;
   logic         encrypt_o, last_out_o;
   logic [1:0]   alg_o, chain_o, start_o, cfb_size_o;
   logic [63:0]  key_a_o, key_b_o, key_c_o;

   always #10 clk = ~clk;

   cipher_modekey_ctl uut (.*);

   int total = 0;
   int bad   = 0;

   logic [31:0] m_mode;
   logic        m_lock, m_filled;
   logic [63:0] m_sw [3];
   logic [63:0] m_pk [3];

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] src(int i);
      return m_mode[7] ? m_pk[i] : m_sw[i];
   endfunction

   function automatic logic [63:0] exp_b();
      return (m_mode[2:1] == 2'd0) ? 64'h0 : src(1);
   endfunction

   function automatic logic [63:0] exp_c();
      if (m_mode[2:1] != 2'd1) return 64'h0;
      return m_mode[4] ? src(0) : src(2);
   endfunction

   function automatic logic [31:0] mode_next(logic [31:0] old, logic [31:0] d);
      logic [31:0] n;
      n = d & MASK;
      if (d[2:1] == 2'b11) n[2:1] = old[2:1];
      return n;
   endfunction

   // compares all ports with the model; req names the requirement under test
   task automatic check_all(string req);
      chk(req, "mode_rd", {32'h0, mode_rd_o}, {32'h0, m_mode});
      chk(req, "fields", {47'h0, encrypt_o, alg_o, chain_o, start_o, cfb_size_o, last_out_o},
          {47'h0, m_mode[0], m_mode[2:1], m_mode[13:12], m_mode[9:8], m_mode[17:16], m_mode[15]});
      chk(req, "key_a", key_a_o, src(0));
      chk(req, "key_b", key_b_o, exp_b());
      chk(req, "key_c", key_c_o, exp_c());
   endtask

   task automatic idle();
      mode_wr_en = 0; mode_wr_prot = 0; mode_wr_data = '0;
      key_wr_en = 0; key_wr_idx = '0; key_wr_data = '0;
      pk_load = 0; pk_data = '0; tamper_i = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      m_mode = 32'h2; m_lock = 0; m_filled = 0;
      for (int i = 0; i < 3; i++) begin m_sw[i] = '0; m_pk[i] = '0; end
   endtask

   task automatic wr_mode(logic [31:0] d, logic prot);
      mode_wr_en = 1; mode_wr_prot = prot; mode_wr_data = d;
      @(negedge clk);
      idle();
      if (!prot) begin
         m_mode = mode_next(m_mode, d);
         if (d[6]) m_lock = 1;
      end
   endtask

   task automatic wr_key(logic [2:0] idx, logic [31:0] d, logic tmp);
      key_wr_en = 1; key_wr_idx = idx; key_wr_data = d; tamper_i = tmp;
      @(negedge clk);
      idle();
      if (tmp && m_mode[31]) begin
         for (int i = 0; i < 3; i++) m_sw[i] = '0;
      end else if (idx < 3'd6) begin
         if (idx[0]) m_sw[idx >> 1][63:32] = d;
         else        m_sw[idx >> 1][31:0]  = d;
      end
   endtask

   task automatic load_pk(logic [191:0] d);
      pk_load = 1; pk_data = d;
      @(negedge clk);
      idle();
      if (!m_lock || !m_filled) begin
         m_pk[0] = d[63:0]; m_pk[1] = d[127:64]; m_pk[2] = d[191:128];
         m_filled = 1;
      end
   endtask

   task automatic pulse_tamper();
      tamper_i = 1;
      @(negedge clk);
      idle();
      if (m_mode[31]) for (int i = 0; i < 3; i++) m_sw[i] = '0;
   endtask

   function automatic logic [191:0] rnd192();
      return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h00C1_F3A5);
      idle();
      rst_n = 0;
      do_reset();
      // R1 reset state
      check_all("R1");

      // R5 software key words, even index = low half
      for (int i = 0; i < 6; i++) wr_key(3'(i), 32'h1000_0000 * (i + 1) + 32'h55, 1'b0);
      check_all("R5");
      wr_key(3'd6, 32'hDEAD_BEEF, 1'b0);
      wr_key(3'd7, 32'hFEED_F00D, 1'b0);
      check_all("R5");

      // R10 routing per algorithm
      wr_mode(32'h0000_0012, 1'b0); check_all("R10");
      wr_mode(32'h0000_0000, 1'b0); check_all("R10");
      wr_mode(32'h0000_0004, 1'b0); check_all("R10");

      // R3 protected write ignored
      wr_mode(32'h0003_3301, 1'b1); check_all("R3");

      // R4 reserved algorithm value keeps XTEA, other fields stored
      wr_mode(32'h0002_2107, 1'b0); check_all("R4");

      // R2 every defined field set (algorithm triple)
      wr_mode(32'hFFFF_FFBB & ~32'h40, 1'b0); check_all("R2");

      // R8 unlocked: repeated loads; R9 private source
      wr_mode(32'h0000_0082, 1'b0);
      load_pk(rnd192()); check_all("R8");
      load_pk(rnd192()); check_all("R8");
      wr_mode(32'h0000_0002, 1'b0); check_all("R9");

      // R6 tamper disarmed, then armed, then tamper against a key write
      pulse_tamper(); check_all("R6");
      wr_mode(32'h8000_0002, 1'b0);
      pulse_tamper(); check_all("R6");
      wr_key(3'd1, 32'hAAAA_5555, 1'b0);
      wr_key(3'd2, 32'h1234_5678, 1'b1); check_all("R6");

      // R7/R8 lock after reset: one load only, write of 0 does not release
      do_reset();
      wr_mode(32'h0000_00C2, 1'b0);
      load_pk(rnd192()); check_all("R8");
      load_pk(rnd192()); check_all("R8");
      wr_mode(32'h0000_0082, 1'b0);
      chk("R7", "pkwo readback", {63'h0, mode_rd_o[6]}, 64'h0);
      load_pk(rnd192()); check_all("R7");

      // random mix
      do_reset();
      for (int n = 0; n < 800; n++) begin
         int unsigned op;
         op = $urandom_range(0, 99);
         if (op < 30)      wr_mode($urandom & ~(($urandom_range(0, 9) == 0) ? 32'h0 : 32'h40),
                                   ($urandom_range(0, 3) == 0));
         else if (op < 65) wr_key(3'($urandom_range(0, 7)), $urandom, ($urandom_range(0, 9) == 0));
         else if (op < 85) load_pk(rnd192());
         else if (op < 97) pulse_tamper();
         else              do_reset();
         check_all("R2");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule